// File: doc/BRIEF.md
# Asynchronous SRAM byte-lane controller

This block sits between a synchronous host and an external asynchronous static RAM of 32K words by 16 bits whose control lines are active low. The host raises a request with a write flag, a 15-bit word address, 16 bits of write data and a 2-bit lane mask. The controller turns that request into a timed strobe sequence on the memory pins and answers with a one-cycle done pulse. For reads, the done pulse comes with the returned data.

The two byte lanes of the memory have separate enable strobes. The mask picks which lanes take part, and bit 0 of the mask is the low lane. The active part of every access is stretched over a number of clocks set by the parameter `WAIT_CYCLES`, so the memory's access time is met at any clock rate. The data bus is split into an output value, an output enable and an input value. The controller enables its own drivers only in write phases, while the memory's output enable is high.

Top module: `sram_lane_ctrl`

## Requirements
- R1: During reset and while idle, `mem_ce_n`, `mem_we_n`, `mem_oe_n`, `mem_lb_n` and `mem_ub_n` are all 1, `mem_dq_oe` is 0, `req_ready` is 1 and `rsp_done` is 0.
- R2: A write request with a non-zero mask is followed, from the next cycle, by exactly `WAIT_CYCLES` cycles with `mem_ce_n`=0, `mem_we_n`=0, `mem_oe_n`=1 and `mem_dq_oe`=1, with the request's address on `mem_addr` and its data on `mem_dq_out`.
- R3: A read request with a non-zero mask is followed, from the next cycle, by exactly `WAIT_CYCLES` cycles with `mem_ce_n`=0, `mem_oe_n`=0, `mem_we_n`=1 and `mem_dq_oe`=0, with the request's address on `mem_addr`.
- R4: In the active cycles, `mem_lb_n` is 0 exactly when mask bit 0 is set (data bits 7:0), and `mem_ub_n` is 0 exactly when mask bit 1 is set (data bits 15:8). Only the selected lanes of the memory change on a write.
- R5: A read samples `mem_dq_in` in its last active cycle. `rsp_rdata` then shows the sampled bits for the selected lanes and zero for the lanes that were not selected.
- R6: The cycle after the active phase is a completion cycle. In it, `rsp_done` is 1 for exactly that one cycle, all strobes are 1 and `mem_addr` is unchanged. `req_ready` returns to 1 in the following cycle.
- R7: A request with mask 2'b00 asserts no strobe and no driver. Its `rsp_done` comes in the cycle after acceptance, and memory contents are unchanged.
- R8: A request is taken only in a cycle where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from acceptance until the completion cycle ends, and `req_valid` is ignored in that time.
- R9: `mem_we_n` and `mem_oe_n` are never 0 together, and `mem_dq_oe` is 0 whenever `mem_oe_n` is 0.
- R10: In the completion cycle of a write, `mem_dq_oe` stays 1 and `mem_dq_out` and `mem_addr` keep the written values. This gives data hold after the write strobe rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane select, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| req_ready | output | 1 | Controller idle, request accepted when valid |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read result, unselected lanes zero |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_lb_n | output | 1 | Low byte lane enable, active low |
| mem_ub_n | output | 1 | High byte lane enable, active low |
| mem_addr | output | 15 | Memory address |
| mem_dq_out | output | 16 | Value driven onto the data bus |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_dq_in | input | 16 | Value read from the data bus |

## Verification
The assertions assume the host holds `req_valid` and its fields steady only as far as the handshake needs, and that `mem_dq_in` is settled by the last active cycle of a read. The bench drives every request on the falling edge and removes it right after acceptance. The one exception is a deliberate busy-time request, which is dropped before the controller goes idle again. The bench's memory model drives the bus only under the pin conditions that make the memory output. It places a fixed non-zero pattern on any lane that is floating, so a missing lane mask in the read path shows up as wrong data.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

    localparam int ADDR_W = 15;
    localparam int DATA_W = 16;
    localparam int LANE_W = 8;
    localparam int LANES  = DATA_W / LANE_W;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ACT  = 2'd1,
        PH_FIN  = 2'd2
    } phase_t;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [LANES-1:0]  mask;
    } host_req_t;

    typedef struct packed {
        logic             ce_n;
        logic             we_n;
        logic             oe_n;
        logic [LANES-1:0] lane_n;
    } strobe_t;

    localparam strobe_t STROBE_OFF = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, lane_n: '1};

    // Spread a per-lane mask over the full data width.
    function automatic logic [DATA_W-1:0] lane_bits(input logic [LANES-1:0] m);
        logic [DATA_W-1:0] r;
        for (int i = 0; i < LANES; i++) begin
            r[i*LANE_W +: LANE_W] = {LANE_W{m[i]}};
        end
        return r;
    endfunction

endpackage

// File: rtl/slc_wait_timer.sv
module slc_wait_timer #(
    parameter int unsigned WAIT_CYCLES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic run,
    output logic last
);
    localparam int CW = (WAIT_CYCLES > 1) ? $clog2(WAIT_CYCLES) : 1;
    localparam logic [CW-1:0] END_VAL = CW'(WAIT_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= '0;
        end else if (run && !last) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign last = (cnt == END_VAL);
endmodule

// File: rtl/slc_read_lanes.sv
module slc_read_lanes
    import sram_lane_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [LANES-1:0]  mask,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] rdata
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                rdata[g*LANE_W +: LANE_W] <= '0;
            end else if (capture) begin
                rdata[g*LANE_W +: LANE_W] <= mask[g] ? bus_in[g*LANE_W +: LANE_W] : '0;
            end
        end
    end
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
    import sram_lane_pkg::*;
#(
    parameter int unsigned WAIT_CYCLES = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_mask,
    output logic              req_ready,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic              mem_lb_n,
    output logic              mem_ub_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    phase_t    phase;
    host_req_t cur;
    strobe_t   stb;
    logic      accept;
    logic      act_last;
    logic      in_act;

    assign accept = req_valid && (phase == PH_IDLE);
    assign in_act = (phase == PH_ACT);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cur   <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: if (accept) begin
                    cur   <= '{wr: req_write, addr: req_addr, wdata: req_wdata, mask: req_mask};
                    phase <= (|req_mask) ? PH_ACT : PH_FIN;
                end
                PH_ACT:  if (act_last) phase <= PH_FIN;
                PH_FIN:  phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    slc_wait_timer #(.WAIT_CYCLES(WAIT_CYCLES)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (accept),
        .run   (in_act),
        .last  (act_last)
    );

    slc_read_lanes u_rd (
        .clk     (clk),
        .rst     (rst),
        .capture (in_act && act_last && !cur.wr),
        .mask    (cur.mask),
        .bus_in  (mem_dq_in),
        .rdata   (rsp_rdata)
    );

    // Strobes decode from registered phase and request only.
    always_comb begin
        stb = STROBE_OFF;
        if (in_act) begin
            stb.ce_n   = 1'b0;
            stb.we_n   = !cur.wr;
            stb.oe_n   = cur.wr;
            stb.lane_n = ~cur.mask;
        end
    end

    assign mem_ce_n   = stb.ce_n;
    assign mem_we_n   = stb.we_n;
    assign mem_oe_n   = stb.oe_n;
    assign mem_lb_n   = stb.lane_n[0];
    assign mem_ub_n   = stb.lane_n[1];
    assign mem_addr   = cur.addr;
    assign mem_dq_out = cur.wdata;
    assign mem_dq_oe  = cur.wr && (|cur.mask) && (phase != PH_IDLE);
    assign req_ready  = (phase == PH_IDLE);
    assign rsp_done   = (phase == PH_FIN);
endmodule

// File: rtl/slc_checker.sv
module slc_checker
    import sram_lane_pkg::*;
#(
    parameter int unsigned WAIT_CYCLES = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_done,
    input logic              mem_ce_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_lb_n,
    input logic              mem_ub_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_dq_oe
);
    logic [31:0] low_run;

    always_ff @(posedge clk) begin
        if (rst || mem_ce_n) low_run <= '0;
        else                 low_run <= low_run + 1;
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && mem_lb_n && mem_ub_n && !rsp_done)); // R1
    AST_ACT_LENGTH: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_ce_n) |-> (low_run == 32'(WAIT_CYCLES))); // R2
    AST_ACT_BOUND: assert property (@(posedge clk) disable iff (rst)
        (low_run <= 32'(WAIT_CYCLES))); // R3
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        !mem_ce_n |=> (mem_ce_n ? rsp_done : 1'b1) && $stable(mem_addr)); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done); // R6
    AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready); // R8
    AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(!mem_we_n && !mem_oe_n)); // R9
    AST_NO_FIGHT: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> !mem_dq_oe); // R9
endmodule

bind sram_lane_ctrl slc_checker #(.WAIT_CYCLES(WAIT_CYCLES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .mem_ce_n  (mem_ce_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_lb_n  (mem_lb_n),
    .mem_ub_n  (mem_ub_n),
    .mem_addr  (mem_addr),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_lane_ctrl_bench.sv
module sram_lane_ctrl_bench;
    import sram_lane_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WAITS      = 3;
    localparam logic [7:0] FLOAT_PAT = 8'h5A;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr  = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic [LANES-1:0]  req_mask  = '0;
    logic              req_ready, rsp_done;
    logic [DATA_W-1:0] rsp_rdata, mem_dq_out, mem_dq_in;
    logic              mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe;
    logic [ADDR_W-1:0] mem_addr;

    int checks = 0;
    int fails  = 0;

    logic [15:0] sram    [int];
    logic [15:0] ref_mem [int];

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_lane_ctrl #(.WAIT_CYCLES(WAITS)) u_sram_lane_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .req_ready(req_ready), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n), .mem_addr(mem_addr),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    function automatic logic [15:0] sram_get(input int a);
        return sram.exists(a) ? sram[a] : 16'h0000;
    endfunction

    function automatic logic [15:0] ref_get(input int a);
        return ref_mem.exists(a) ? ref_mem[a] : 16'h0000;
    endfunction

    // Behavioural memory: outputs a lane only when selected for a read.
    logic mem_out_lo, mem_out_hi;
    always_comb begin
        logic [15:0] w;
        w = sram_get(int'(mem_addr));
        mem_out_lo = !mem_ce_n && !mem_oe_n && mem_we_n && !mem_lb_n;
        mem_out_hi = !mem_ce_n && !mem_oe_n && mem_we_n && !mem_ub_n;
        mem_dq_in[7:0]  = mem_dq_oe ? mem_dq_out[7:0]  : (mem_out_lo ? w[7:0]  : FLOAT_PAT);
        mem_dq_in[15:8] = mem_dq_oe ? mem_dq_out[15:8] : (mem_out_hi ? w[15:8] : FLOAT_PAT);
    end

    always @(posedge clk) begin
        if (!rst && !mem_ce_n && !mem_we_n && mem_dq_oe) begin
            logic [15:0] w;
            w = sram_get(int'(mem_addr));
            if (!mem_lb_n) w[7:0]  = mem_dq_out[7:0];
            if (!mem_ub_n) w[15:8] = mem_dq_out[15:8];
            sram[int'(mem_addr)] = w;
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Pin-level rules checked on every cycle.
    always @(negedge clk) begin
        if (!rst) begin
            chk(!(!mem_we_n && !mem_oe_n), "R9 we/oe both low", {mem_we_n, mem_oe_n}, 2'b11);
            chk(!(mem_dq_oe && (mem_out_lo || mem_out_hi)), "R9 bus contention", mem_dq_oe, 0);
            chk(!(!mem_ce_n && !mem_we_n && !mem_dq_oe), "R2 write without drive", mem_dq_oe, 1);
        end
    end

    task automatic check_idle(input string tag);
        chk({mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n} == 5'b11111, tag,
            {mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n}, 5'b11111);
        chk(!mem_dq_oe && req_ready && !rsp_done, tag, {mem_dq_oe, req_ready, rsp_done}, 3'b010);
    endtask

    // One access, checked cycle by cycle against the requirements.
    task automatic access(input logic wr, input logic [14:0] a, input logic [15:0] d,
                          input logic [1:0] m, input logic busy_poke);
        logic [15:0] lm, exp_rd;
        lm = lane_bits(m);
        chk(req_ready, "R8 ready before request", req_ready, 1);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
        @(posedge clk);
        @(negedge clk);
        if (busy_poke) begin
            req_addr = a ^ 15'h2AAA; req_wdata = ~d; req_write = !wr;
        end else begin
            req_valid = 1'b0;
        end
        if (m != 2'b00) begin
            for (int c = 0; c < WAITS; c++) begin
                chk(!mem_ce_n && !req_ready && !rsp_done, wr ? "R2 active" : "R3 active",
                    {mem_ce_n, req_ready, rsp_done}, 3'b000);
                chk(mem_we_n == !wr && mem_oe_n == wr && mem_dq_oe == wr, wr ? "R2 strobes" : "R3 strobes",
                    {mem_we_n, mem_oe_n, mem_dq_oe}, {!wr, wr, wr});
                chk(mem_lb_n == !m[0] && mem_ub_n == !m[1], "R4 lane strobes",
                    {mem_lb_n, mem_ub_n}, {!m[0], !m[1]});
                chk(mem_addr == a, busy_poke ? "R8 busy request ignored" : "R2 address",
                    mem_addr, a);
                if (wr) chk(mem_dq_out == d, "R2 write data", mem_dq_out, d);
                @(negedge clk);
            end
        end
        // Completion cycle.
        if (busy_poke) req_valid = 1'b0;
        chk(rsp_done && !req_ready, m == 2'b00 ? "R7 done for empty mask" : "R6 done",
            {rsp_done, req_ready}, 2'b10);
        chk({mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n} == 5'b11111,
            m == 2'b00 ? "R7 no strobes" : "R6 strobes off",
            {mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n}, 5'b11111);
        chk(mem_addr == a, "R6 address held", mem_addr, a);
        if (wr && m != 2'b00) begin
            chk(mem_dq_oe && mem_dq_out == d, "R10 write data hold", {mem_dq_oe, mem_dq_out}, {1'b1, d});
            ref_mem[int'(a)] = (ref_get(int'(a)) & ~lm) | (d & lm);
        end else begin
            chk(!mem_dq_oe, m == 2'b00 ? "R7 no drive" : "R9 no drive on read", mem_dq_oe, 0);
        end
        if (!wr && m != 2'b00) begin
            exp_rd = ref_get(int'(a)) & lm;
            chk(rsp_rdata == exp_rd, "R5 read data", rsp_rdata, exp_rd);
        end
        @(negedge clk);
        chk(!rsp_done && req_ready, "R6 ready after done", {rsp_done, req_ready}, 2'b01);
        chk(sram_get(int'(a)) == ref_get(int'(a)), m == 2'b00 ? "R7 memory unchanged" : "R4 lane write",
            sram_get(int'(a)), ref_get(int'(a)));
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] x;
        @(negedge clk);
        check_idle("R1 in reset");
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_idle("R1 idle after reset");

        access(1'b1, 15'h0010, 16'h1234, 2'b11, 1'b0);
        access(1'b0, 15'h0010, 16'h0000, 2'b11, 1'b0);
        access(1'b1, 15'h0010, 16'hABCD, 2'b01, 1'b0);   // R4 low lane only
        access(1'b1, 15'h0010, 16'h56EF, 2'b10, 1'b0);   // R4 high lane only
        access(1'b0, 15'h0010, 16'h0000, 2'b01, 1'b0);   // R5 low lane read
        access(1'b0, 15'h0010, 16'h0000, 2'b10, 1'b0);   // R5 high lane read
        access(1'b0, 15'h0010, 16'h0000, 2'b11, 1'b0);
        access(1'b1, 15'h0010, 16'hFFFF, 2'b00, 1'b0);   // R7 empty write
        access(1'b0, 15'h0010, 16'h0000, 2'b00, 1'b0);   // R7 empty read
        access(1'b0, 15'h0010, 16'h0000, 2'b11, 1'b0);
        access(1'b1, 15'h7FFF, 16'hC3A5, 2'b11, 1'b0);
        access(1'b1, 15'h0000, 16'h0F0F, 2'b11, 1'b1);   // R8 busy-time request
        access(1'b0, 15'h7FFF, 16'h0000, 2'b11, 1'b1);
        access(1'b0, 15'h0000, 16'h0000, 2'b11, 1'b0);
        access(1'b0, 15'h2AAA, 16'h0000, 2'b11, 1'b0);   // busy poke address never written

        x = 32'h1F2E3D4C;
        for (int i = 0; i < 40; i++) begin
            x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
            access(x[0], {12'h100, x[3:1]}, x[31:16], x[5:4], 1'b0);
        end
        for (int i = 0; i < 8; i++) begin
            access(1'b0, {12'h100, 3'(i)}, 16'h0000, 2'b11, 1'b0);
        end

        check_idle("R1 idle at end");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule